// File: doc/BRIEF.md
# Memory Region Attribute Register File

This block holds a cacheability bit and a prefetchability bit for each 16 MB region of a 4 GB logical address space. There are 256 regions. Software programs the bits through a register write port and reads them back through a separate register read port. A memory pipeline presents a 32-bit address on a lookup port. One cycle later it gets back the two attribute bits for the region that holds that address.

The lowest sixteen registers describe the core's own internal memory and cannot be written. A write to one of them is dropped and raises a sticky error flag, which software clears with a dedicated strobe. Each register is 32 bits wide, but only two bits exist: bit 0 means cacheable and bit 3 means prefetchable. Every other bit reads as zero, and writes to those bits have no effect. After reset, every attribute bit is zero.

Top module: `mem_attr_lookup`

## Requirements
- R1: Register index k (0 to 255) covers addresses k*16 MB to k*16 MB + 16 MB - 1. The lookup selects the register by address bits 31:24, and the register ports select it by their 8-bit index.
- R2: Register bit 0 is the cacheable attribute. It reads back as written, and a lookup returns it on `lkCacheable`.
- R3: Register bit 3 is the prefetchable attribute. It reads back as written, and a lookup returns it on `lkPrefetchable`.
- R4: All register bits other than 0 and 3 always read as zero, whatever value was written.
- R5: Registers 0 to 15 are read-only. Writes to them change nothing, they read as zero, and lookups that fall in their regions return zero for both attributes.
- R6: A write to registers 0 to 15 sets `errFlag` on the next cycle. The flag stays set until `errClr` is pulsed. If a read-only write and `errClr` arrive in the same cycle, the flag ends up set.
- R7: Reset clears every attribute bit, the error flag, the read data, the read-valid output and the lookup outputs.
- R8: `regRdValid` is high exactly one cycle after `regRdEn`, with `regRdData` holding the register. A write to the same register in the same cycle as the read is not visible until a later read.
- R9: Lookup results and `lkRespValid` appear one cycle after `lkReq`. The result reflects the attributes as they were before any write in the request cycle. When `lkReq` is low, the attribute outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 8 | Register index to write |
| regWrData | input | 32 | Write data (only bits 0 and 3 are used) |
| regRdEn | input | 1 | Register read strobe |
| regRdAddr | input | 8 | Register index to read |
| regRdData | output | 32 | Read data, valid with regRdValid |
| regRdValid | output | 1 | Read data valid, one cycle after regRdEn |
| errClr | input | 1 | Clears the sticky error flag |
| errFlag | output | 1 | Sticky flag for a write to a read-only register |
| lkReq | input | 1 | Lookup request |
| lkAddr | input | 32 | Lookup address |
| lkCacheable | output | 1 | Cacheable attribute of the looked-up region |
| lkPrefetchable | output | 1 | Prefetchable attribute of the looked-up region |
| lkRespValid | output | 1 | Lookup result valid, one cycle after lkReq |

## Verification
The hardest cases to reach are collisions in a single cycle. One is a read-only write that lands together with an error clear. Another is a read or lookup that lands on the very register being written in that cycle. Random traffic seldom produces these, because it spreads over 256 indices. So the bench drives them as directed steps, then runs a random phase that confines indices to a narrow window around the read-only boundary, where such collisions become common. A reference model in the bench is updated only after each cycle's expected values are taken, so the bench predicts the pre-write result independently of the design.

// File: rtl/mem_attr_pkg.sv
package mem_attr_pkg;
  localparam int NUM_REGS  = 256;
  localparam int IDX_W     = $clog2(NUM_REGS);

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             wrCache;
    logic             wrPref;
    logic             rdEn;
    logic [IDX_W-1:0] rdIdx;
    logic             lkEn;
    logic [IDX_W-1:0] lkIdx;
  } attrStrobes_t;
endpackage

// File: rtl/mem_attr_ctrl.sv
module mem_attr_ctrl
  import mem_attr_pkg::*;
#(
  parameter int RO_COUNT  = 16,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CACHE_BIT = 0,
  parameter int PREF_BIT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [IDX_W-1:0]  regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  input  logic [IDX_W-1:0]  regRdAddr,
  input  logic              errClr,
  input  logic              lkReq,
  input  logic [ADDR_W-1:0] lkAddr,
  output attrStrobes_t      strobes,
  output logic              errFlag
);
  localparam logic [IDX_W-1:0] RO_LIMIT = IDX_W'(RO_COUNT);

  logic roWrite;
  logic unusedBits;

  assign roWrite = regWrEn && (regWrAddr < RO_LIMIT);

  always_comb begin
    strobes.wrEn    = regWrEn && !roWrite;
    strobes.wrIdx   = regWrAddr;
    strobes.wrCache = regWrData[CACHE_BIT];
    strobes.wrPref  = regWrData[PREF_BIT];
    strobes.rdEn    = regRdEn;
    strobes.rdIdx   = regRdAddr;
    strobes.lkEn    = lkReq;
    strobes.lkIdx   = lkAddr[ADDR_W-1 -: IDX_W];
  end

  // Bits that carry no attribute are intentionally discarded.
  assign unusedBits = ^{regWrData, lkAddr};

  always_ff @(posedge clk) begin
    if (!rstN)        errFlag <= 1'b0;
    else if (roWrite) errFlag <= 1'b1;
    else if (errClr)  errFlag <= 1'b0;
  end
endmodule

// File: rtl/mem_attr_datapath.sv
module mem_attr_datapath
  import mem_attr_pkg::*;
#(
  parameter int RO_COUNT  = 16,
  parameter int DATA_W    = 32,
  parameter int CACHE_BIT = 0,
  parameter int PREF_BIT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  attrStrobes_t      strobes,
  output logic [DATA_W-1:0] regRdData,
  output logic              regRdValid,
  output logic              lkCacheable,
  output logic              lkPrefetchable,
  output logic              lkRespValid
);
  logic cacheBits [NUM_REGS];
  logic prefBits  [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_region
    if (i < RO_COUNT) begin : g_ro
      assign cacheBits[i] = 1'b0;
      assign prefBits[i]  = 1'b0;
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cacheBits[i] <= 1'b0;
          prefBits[i]  <= 1'b0;
        end else if (strobes.wrEn && strobes.wrIdx == IDX_W'(i)) begin
          cacheBits[i] <= strobes.wrCache;
          prefBits[i]  <= strobes.wrPref;
        end
      end
    end
  end

  logic [DATA_W-1:0] rdWord;
  always_comb begin
    rdWord            = '0;
    rdWord[CACHE_BIT] = cacheBits[strobes.rdIdx];
    rdWord[PREF_BIT]  = prefBits[strobes.rdIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= strobes.rdEn;
      if (strobes.rdEn) regRdData <= rdWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkCacheable    <= 1'b0;
      lkPrefetchable <= 1'b0;
      lkRespValid    <= 1'b0;
    end else begin
      lkRespValid <= strobes.lkEn;
      if (strobes.lkEn) begin
        lkCacheable    <= cacheBits[strobes.lkIdx];
        lkPrefetchable <= prefBits[strobes.lkIdx];
      end
    end
  end
endmodule

// File: rtl/mem_attr_lookup.sv
module mem_attr_lookup
  import mem_attr_pkg::*;
#(
  parameter int RO_COUNT  = 16,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CACHE_BIT = 0,
  parameter int PREF_BIT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrAddr,
  input  logic [31:0]       regWrData,
  input  logic              regRdEn,
  input  logic [7:0]        regRdAddr,
  output logic [31:0]       regRdData,
  output logic              regRdValid,
  input  logic              errClr,
  output logic              errFlag,
  input  logic              lkReq,
  input  logic [31:0]       lkAddr,
  output logic              lkCacheable,
  output logic              lkPrefetchable,
  output logic              lkRespValid
);
  attrStrobes_t strobes;

  mem_attr_ctrl #(
    .RO_COUNT(RO_COUNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CACHE_BIT(CACHE_BIT), .PREF_BIT(PREF_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdAddr(regRdAddr),
    .errClr(errClr), .lkReq(lkReq), .lkAddr(lkAddr),
    .strobes(strobes), .errFlag(errFlag)
  );

  mem_attr_datapath #(
    .RO_COUNT(RO_COUNT), .DATA_W(DATA_W),
    .CACHE_BIT(CACHE_BIT), .PREF_BIT(PREF_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .regRdData(regRdData), .regRdValid(regRdValid),
    .lkCacheable(lkCacheable), .lkPrefetchable(lkPrefetchable),
    .lkRespValid(lkRespValid)
  );
endmodule

// File: rtl/mem_attr_checker.sv
module mem_attr_checker #(
  parameter int RO_COUNT = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [7:0]  regWrAddr,
  input logic        regRdEn,
  input logic [7:0]  regRdAddr,
  input logic [31:0] regRdData,
  input logic        regRdValid,
  input logic        errClr,
  input logic        errFlag,
  input logic        lkReq,
  input logic [31:0] lkAddr,
  input logic        lkCacheable,
  input logic        lkPrefetchable,
  input logic        lkRespValid
);
  localparam logic [7:0] RO_LIMIT = 8'(RO_COUNT);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdValid |-> ((regRdData & ~32'h0000_0009) == 32'h0)); // R4
  AST_RD_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid); // R8
  AST_RD_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> !regRdValid); // R8
  AST_LK_VALID: assert property (@(posedge clk) disable iff (!rstN)
    lkReq |=> lkRespValid); // R9
  AST_LK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !lkReq |=> ($stable(lkCacheable) && $stable(lkPrefetchable) && !lkRespValid)); // R9
  AST_RO_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regRdAddr < RO_LIMIT) |=> (regRdData == 32'h0)); // R5
  AST_RO_LOOKUP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (lkReq && lkAddr[31:24] < RO_LIMIT) |=> (!lkCacheable && !lkPrefetchable)); // R5
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrAddr < RO_LIMIT) |=> errFlag); // R6
  AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && !(regWrEn && regWrAddr < RO_LIMIT)) |=> !errFlag); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag); // R6
endmodule

bind mem_attr_lookup mem_attr_checker #(.RO_COUNT(RO_COUNT)) u_chk (.*);

// File: tb/mem_attr_lookup_tb.sv
`timescale 1ns/1ps
module mem_attr_lookup_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn, regRdEn, errClr, lkReq;
  logic [7:0]  regWrAddr, regRdAddr;
  logic [31:0] regWrData, regRdData, lkAddr;
  logic        regRdValid, errFlag, lkCacheable, lkPrefetchable, lkRespValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  bit mCache [256];
  bit mPref  [256];
  bit mErr;

  always #5 clk = ~clk;

  mem_attr_lookup u_dut (.*);

  function automatic logic [31:0] expWord(int idx);
    return {28'h0, mPref[idx], 2'b00, mCache[idx]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 256; i++) begin mCache[i] = 0; mPref[i] = 0; end
    mErr = 0;
  endtask

  // One cycle: drive at negedge, check at following negedge, then update model.
  task automatic step(bit wr, logic [7:0] wa, logic [31:0] wd, bit rd, logic [7:0] ra,
                      bit lk, logic [31:0] la, bit clr, string tag);
    logic [31:0] eRd;
    bit eC, eP, roWr;
    regWrEn = wr; regWrAddr = wa; regWrData = wd;
    regRdEn = rd; regRdAddr = ra; lkReq = lk; lkAddr = la; errClr = clr;
    eRd = expWord(ra);
    eC = mCache[la[31:24]]; eP = mPref[la[31:24]];
    roWr = wr && (wa < 8'd16);
    @(posedge clk); @(negedge clk);
    chk({tag, " R8 rdValid"}, {31'h0, regRdValid}, {31'h0, rd});
    if (rd) chk({tag, " R8 rdData"}, regRdData, eRd);
    chk({tag, " R9 lkValid"}, {31'h0, lkRespValid}, {31'h0, lk});
    if (lk) chk({tag, " R1 lookup"}, {30'h0, lkPrefetchable, lkCacheable}, {30'h0, eP, eC});
    if (roWr) mErr = 1; else if (clr) mErr = 0;
    chk({tag, " R6 errFlag"}, {31'h0, errFlag}, {31'h0, mErr});
    if (wr && !roWr) begin mCache[wa] = wd[0]; mPref[wa] = wd[3]; end
    regWrEn = 0; regRdEn = 0; lkReq = 0; errClr = 0;
  endtask

  task automatic doReset();
    rstN = 0; regWrEn = 0; regRdEn = 0; lkReq = 0; errClr = 0;
    regWrAddr = 0; regRdAddr = 0; regWrData = 0; lkAddr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    modelReset();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();
    // R7: reset state at the ports
    chk("R7 rdValid after reset", {31'h0, regRdValid}, 32'h0);
    chk("R7 errFlag after reset", {31'h0, errFlag}, 32'h0);
    chk("R7 lk outputs after reset", {30'h0, lkPrefetchable, lkCacheable}, 32'h0);
    step(0, 0, 0, 1, 8'd20, 1, 32'hFF00_0000, 0, "R7 reset reg");
    // R2 R3 R4: all-ones write keeps only bits 0 and 3
    step(1, 8'd16, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R2 wr16");
    step(0, 0, 0, 1, 8'd16, 0, 0, 0, "R4 rd16");
    chk("R4 reserved zero", regRdData, 32'h0000_0009);
    // R1: lookup by top address byte
    step(0, 0, 0, 0, 0, 1, 32'h10AB_CDEF, 0, "R1 lk16");
    chk("R2 lkCacheable", {31'h0, lkCacheable}, 32'h1);
    step(1, 8'd255, 32'h0000_0008, 0, 0, 0, 0, 0, "R3 wr255");
    step(0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, 0, "R3 lk255");
    chk("R3 lkPrefetchable", {30'h0, lkPrefetchable, lkCacheable}, 32'h2);
    // R5 R6: read-only write
    step(1, 8'd5, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R5 wrRO");
    chk("R6 errFlag set", {31'h0, errFlag}, 32'h1);
    step(0, 0, 0, 1, 8'd5, 1, 32'h05FF_FFFF, 0, "R5 rdRO");
    chk("R5 RO reads zero", regRdData, 32'h0);
    step(0, 0, 0, 0, 0, 0, 0, 1, "R6 clr");
    chk("R6 errFlag cleared", {31'h0, errFlag}, 32'h0);
    step(1, 8'd15, 32'h1, 0, 0, 0, 0, 1, "R6 set wins");
    chk("R6 set beats clear", {31'h0, errFlag}, 32'h1);
    step(1, 8'd16, 32'h0, 0, 0, 0, 0, 1, "R6 clr rw");
    // R8 R9: same-cycle write and read/lookup see old value
    step(1, 8'd40, 32'h9, 1, 8'd40, 1, 32'h2800_0000, 0, "R8 collide");
    chk("R8 old value", regRdData, 32'h0);
    step(0, 0, 0, 1, 8'd40, 0, 0, 0, "R8 after");
    chk("R8 new value", regRdData, 32'h9);
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9 hold");
    chk("R9 hold outputs", {30'h0, lkPrefetchable, lkCacheable}, 32'h0);
    // Random phase near the read-only boundary and across the space
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] wa, ra, li;
      wa = (n % 2) ? 8'($urandom_range(8, 24)) : 8'($urandom);
      ra = (n % 3) ? 8'($urandom_range(8, 24)) : 8'($urandom);
      li = (n % 2) ? 8'($urandom_range(8, 24)) : 8'($urandom);
      step(($urandom % 2) == 0, wa, $urandom, ($urandom % 2) == 0, ra,
           ($urandom % 2) == 0, {li, 24'($urandom)}, ($urandom % 8) == 0, "rand");
    end
    // R7: reset mid-run clears everything
    @(negedge clk);
    doReset();
    step(0, 0, 0, 1, 8'd40, 1, 32'h1000_0000, 0, "R7 re-reset");
    chk("R7 reg cleared", regRdData, 32'h0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule